// File: doc/BRIEF.md
# Memory-Mapped Device Decoder with Display and Switch Port

This block sits between an 8-bit microprocessor with a 12-bit address bus and its few peripherals. The three most significant address bits name one of eight device slots. The nine low bits travel unchanged to the device as an offset, so each slot covers 512 locations. The block drives active-low chip enables to an external ROM and an external RAM. It holds an 8-bit output register that feeds a display, and it samples an 8-bit bank of switches.

Read data comes back through a multiplexer that takes the place of a shared tri-state data bus. The multiplexer forwards only the selected device's byte. When nothing valid is selected, it returns all ones, the value an undriven bus would float to.

The slot codes are fixed:
- 0 is empty.
- 1 is ROM.
- 2 is RAM.
- 3 is the display.
- 4 is the switches.
- 5 to 7 are spare.

For example, RAM offset 0x056 is reached at full address 0x456. Every address from 0x600 to 0x7FF reaches the display.

Top module: `mmio_decoder`

## Requirements
- R1: While `bus_rd` or `bus_wr` is high and `cpu_addr[11:9]` equals 1, `rom_sel_n` is low in the same cycle.
- R2: While `bus_rd` or `bus_wr` is high and `cpu_addr[11:9]` equals 2, `ram_sel_n` is low in the same cycle. Address 0x456 selects RAM with `dev_offset` equal to 0x056.
- R3: At most one of `rom_sel_n` and `ram_sel_n` is low at any time. Both are high whenever `bus_rd` and `bus_wr` are both low.
- R4: Slot codes 0, 3, 4, 5, 6 and 7 leave both `rom_sel_n` and `ram_sel_n` high, even during a strobe.
- R5: A cycle with `bus_wr` high and `cpu_addr[11:9]` equal to 3 loads `wdata` into `disp_q` at that clock edge. This holds for every offset in 0x600 to 0x7FF.
- R6: `disp_q` keeps its value in every cycle without a display write. This includes writes to other slots and reads of the display slot.
- R7: A synchronous active-high `rst` sets `disp_q` to 0x00 and clears the switch sample to 0x00.
- R8: A read with `cpu_addr[11:9]` equal to 4 returns `sw_in` as it was sampled at the most recent clock edge. A change of `sw_in` is not visible before the next edge.
- R9: A read with slot 1 returns `rom_rdata`, and a read with slot 2 returns `ram_rdata`, combinationally.
- R10: `rdata` is 0xFF when `bus_rd` is low. It is also 0xFF for reads of slots 0, 3, 5, 6 and 7.
- R11: `dev_offset` always equals `cpu_addr[8:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 12 | CPU address; bits 11:9 pick the slot |
| wdata | input | 8 | CPU write data |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| rom_rdata | input | 8 | Byte returned by the external ROM |
| ram_rdata | input | 8 | Byte returned by the external RAM |
| sw_in | input | 8 | Raw switch levels |
| rom_sel_n | output | 1 | ROM chip enable, active low |
| ram_sel_n | output | 1 | RAM chip enable, active low |
| dev_offset | output | 9 | Offset passed to the selected device |
| disp_q | output | 8 | Display register contents |
| rdata | output | 8 | Read data returned to the CPU |

## Verification
The bench sweeps all eight slot codes with reads, writes and idle cycles.
- A decoder that ignores the strobe gating would assert a chip enable on an idle bus.
- A decoder that compares the wrong bits would select RAM for 0x456 or miss it.

Display writes go to the lowest, highest and a middle offset of the slot. This catches a decoder that wrongly requires offset zero. Writes to neighbouring slots and reads of the display slot must leave the register unchanged, which exposes a load that is not qualified by the write strobe.

The switch port is read just after `sw_in` changes and again after the next edge. A read path that bypasses the sample register shows the new value one cycle too early.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SLOT_EMPTY = 3'd0,
        SLOT_ROM   = 3'd1,
        SLOT_RAM   = 3'd2,
        SLOT_DISP  = 3'd3,
        SLOT_SW    = 3'd4,
        SLOT_SP5   = 3'd5,
        SLOT_SP6   = 3'd6,
        SLOT_SP7   = 3'd7
    } slot_e;

    typedef struct packed {
        logic rom;
        logic ram;
        logic disp_wr;
        logic sw_rd;
        logic rom_rd;
        logic ram_rd;
    } slot_en_t;

endpackage

// File: rtl/mmio_slot_decode.sv
module mmio_slot_decode
    import mmio_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [SEL_W-1:0] slot_code,
    input  logic             rd,
    input  logic             wr,
    output slot_en_t         en
);
    slot_e slot;
    logic  active;

    assign slot   = slot_e'(slot_code);
    assign active = rd | wr;

    always_comb begin
        en = '0;
        unique case (slot)
            SLOT_ROM: begin
                en.rom    = active;
                en.rom_rd = rd;
            end
            SLOT_RAM: begin
                en.ram    = active;
                en.ram_rd = rd;
            end
            SLOT_DISP: en.disp_wr = wr;
            SLOT_SW:   en.sw_rd   = rd;
            SLOT_EMPTY, SLOT_SP5, SLOT_SP6, SLOT_SP7: en = '0;
        endcase
    end
endmodule

// File: rtl/mmio_out_reg.sv
module mmio_out_reg #(
    parameter int          DATA_W  = 8,
    parameter logic [7:0]  RST_VAL = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= DATA_W'(RST_VAL);
        else if (load) q <= d;
    end
endmodule

// File: rtl/mmio_in_sampler.sv
module mmio_in_sampler #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] sampled
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) sampled[i] <= 1'b0;
            else     sampled[i] <= raw[i];
        end
    end
endmodule

// File: rtl/mmio_rd_mux.sv
module mmio_rd_mux
    import mmio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  slot_en_t          en,
    input  logic [DATA_W-1:0] rom_d,
    input  logic [DATA_W-1:0] ram_d,
    input  logic [DATA_W-1:0] sw_d,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        if (en.rom_rd)     rdata = rom_d;
        else if (en.ram_rd) rdata = ram_d;
        else if (en.sw_rd)  rdata = sw_d;
        else                rdata = '1;
    end
endmodule

// File: rtl/mmio_decoder.sv
module mmio_decoder
    import mmio_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    localparam int OFF_W = ADDR_W - SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic [DATA_W-1:0] sw_in,
    output logic              rom_sel_n,
    output logic              ram_sel_n,
    output logic [OFF_W-1:0]  dev_offset,
    output logic [DATA_W-1:0] disp_q,
    output logic [DATA_W-1:0] rdata
);
    slot_en_t          en;
    logic [DATA_W-1:0] sw_q;

    assign dev_offset = cpu_addr[OFF_W-1:0];

    mmio_slot_decode #(.ADDR_W(ADDR_W)) u_dec (
        .slot_code (cpu_addr[ADDR_W-1:OFF_W]),
        .rd        (bus_rd),
        .wr        (bus_wr),
        .en        (en)
    );

    assign rom_sel_n = ~en.rom;
    assign ram_sel_n = ~en.ram;

    mmio_out_reg #(.DATA_W(DATA_W), .RST_VAL(8'h00)) u_disp (
        .clk  (clk),
        .rst  (rst),
        .load (en.disp_wr),
        .d    (wdata),
        .q    (disp_q)
    );

    mmio_in_sampler #(.DATA_W(DATA_W)) u_sw (
        .clk     (clk),
        .rst     (rst),
        .raw     (sw_in),
        .sampled (sw_q)
    );

    mmio_rd_mux #(.DATA_W(DATA_W)) u_mux (
        .en    (en),
        .rom_d (rom_rdata),
        .ram_d (ram_rdata),
        .sw_d  (sw_q),
        .rdata (rdata)
    );
endmodule

// File: rtl/mmio_decoder_chk.sv
module mmio_decoder_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    parameter int OFF_W  = 9
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] wdata,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] rom_rdata,
    input logic [DATA_W-1:0] ram_rdata,
    input logic              rom_sel_n,
    input logic              ram_sel_n,
    input logic [OFF_W-1:0]  dev_offset,
    input logic [DATA_W-1:0] disp_q,
    input logic [DATA_W-1:0] rdata
);
    logic [2:0] code;
    logic       disp_wr;
    assign code    = cpu_addr[ADDR_W-1:OFF_W];
    assign disp_wr = bus_wr && code == 3'd3;

    AST_ROM_SELECT: assert property (@(posedge clk) disable iff (rst)
        (bus_rd || bus_wr) && code == 3'd1 |-> !rom_sel_n);              // R1
    AST_RAM_SELECT: assert property (@(posedge clk) disable iff (rst)
        (bus_rd || bus_wr) && code == 3'd2 |-> !ram_sel_n);              // R2
    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(!rom_sel_n && !ram_sel_n));                                     // R3
    AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (rst)
        !bus_rd && !bus_wr |-> rom_sel_n && ram_sel_n);                   // R3
    AST_OTHER_NO_SEL: assert property (@(posedge clk) disable iff (rst)
        code != 3'd1 && code != 3'd2 |-> rom_sel_n && ram_sel_n);         // R4
    AST_DISP_LOAD: assert property (@(posedge clk) disable iff (rst)
        disp_wr |=> disp_q == $past(wdata));                              // R5
    AST_DISP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !disp_wr |=> $stable(disp_q));                                    // R6
    AST_ROM_DATA: assert property (@(posedge clk) disable iff (rst)
        bus_rd && code == 3'd1 |-> rdata == rom_rdata);                   // R9
    AST_IDLE_FILL: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> rdata == 8'hFF);                                      // R10
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        dev_offset == cpu_addr[OFF_W-1:0]);                               // R11
endmodule

bind mmio_decoder mmio_decoder_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)
) u_chk (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .wdata(wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .rom_rdata(rom_rdata),
    .ram_rdata(ram_rdata), .rom_sel_n(rom_sel_n), .ram_sel_n(ram_sel_n),
    .dev_offset(dev_offset), .disp_q(disp_q), .rdata(rdata)
);

// File: tb/mmio_decoder_bench.sv
module mmio_decoder_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] cpu_addr = '0;
    logic [7:0]  wdata = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  rom_rdata = 8'hA5;
    logic [7:0]  ram_rdata = 8'h3C;
    logic [7:0]  sw_in = 8'h00;
    logic        rom_sel_n, ram_sel_n;
    logic [8:0]  dev_offset;
    logic [7:0]  disp_q, rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmio_decoder u_mmio_decoder (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .wdata(wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .rom_rdata(rom_rdata),
        .ram_rdata(ram_rdata), .sw_in(sw_in), .rom_sel_n(rom_sel_n),
        .ram_sel_n(ram_sel_n), .dev_offset(dev_offset), .disp_q(disp_q),
        .rdata(rdata)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [11:0] a, input logic r, input logic w, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; bus_rd = r; bus_wr = w; wdata = d;
        #1;
    endtask

    task automatic idle();
        drive(12'h000, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic t_reset();
        check("R7 disp", {8'h00, disp_q}, 16'h0000);
        sw_in = 8'h00;
        drive(12'h800, 1'b1, 1'b0, 8'h00);
        check("R7 sw", {8'h00, rdata}, 16'h0000);
        idle();
    endtask

    task automatic t_select();
        for (int c = 0; c < 8; c++) begin
            for (int m = 0; m < 3; m++) begin
                logic r, w, act;
                r = (m == 1); w = (m == 2); act = r | w;
                drive({c[2:0], 9'h0AB}, r, w, disp_q);
                check(c == 1 ? "R1 rom" : "R4 rom", {15'd0, rom_sel_n}, {15'd0, !(act && c == 1)});
                check(c == 2 ? "R2 ram" : "R4 ram", {15'd0, ram_sel_n}, {15'd0, !(act && c == 2)});
                check("R3 excl", {15'd0, rom_sel_n | ram_sel_n}, 16'd1);
                check("R11 offset", {7'd0, dev_offset}, 16'h00AB);
            end
        end
        drive(12'h456, 1'b1, 1'b0, 8'h00);
        check("R2 0x456 sel", {15'd0, ram_sel_n}, 16'd0);
        check("R2 0x456 off", {7'd0, dev_offset}, 16'h0056);
        idle();
        check("R3 idle", {14'd0, rom_sel_n, ram_sel_n}, 16'd3);
    endtask

    task automatic t_display();
        logic [11:0] addrs [3] = '{12'h600, 12'h6F3, 12'h7FF};
        logic [7:0]  vals  [3] = '{8'h5A, 8'hC3, 8'h81};
        for (int i = 0; i < 3; i++) begin
            drive(addrs[i], 1'b0, 1'b1, vals[i]);
            @(posedge clk); #1;
            check("R5 load", {8'h00, disp_q}, {8'h00, vals[i]});
        end
        drive(12'h455, 1'b0, 1'b1, 8'h11); @(posedge clk); #1;
        check("R6 ram wr", {8'h00, disp_q}, 16'h0081);
        drive(12'h800, 1'b0, 1'b1, 8'h22); @(posedge clk); #1;
        check("R6 sw wr", {8'h00, disp_q}, 16'h0081);
        drive(12'h600, 1'b1, 1'b0, 8'h33); @(posedge clk); #1;
        check("R6 disp rd", {8'h00, disp_q}, 16'h0081);
        check("R10 disp rd", {8'h00, rdata}, 16'h00FF);
        idle(); @(posedge clk); #1;
        check("R6 idle", {8'h00, disp_q}, 16'h0081);
    endtask

    task automatic t_read();
        drive(12'h234, 1'b1, 1'b0, 8'h00);
        check("R9 rom", {8'h00, rdata}, 16'h00A5);
        rom_rdata = 8'h17; #1;
        check("R9 rom live", {8'h00, rdata}, 16'h0017);
        drive(12'h4F0, 1'b1, 1'b0, 8'h00);
        check("R9 ram", {8'h00, rdata}, 16'h003C);
        for (int c = 0; c < 8; c++) begin
            if (c == 0 || c >= 5) begin
                drive({c[2:0], 9'h1FF}, 1'b1, 1'b0, 8'h00);
                check("R10 spare", {8'h00, rdata}, 16'h00FF);
            end
        end
        drive(12'h234, 1'b0, 1'b0, 8'h00);
        check("R10 no rd", {8'h00, rdata}, 16'h00FF);
        drive(12'h234, 1'b0, 1'b1, 8'h00);
        check("R10 wr only", {8'h00, rdata}, 16'h00FF);
        idle();
    endtask

    task automatic t_switch();
        @(negedge clk); sw_in = 8'h96;
        @(posedge clk); #1;
        drive(12'h9C0, 1'b1, 1'b0, 8'h00);
        check("R8 sampled", {8'h00, rdata}, 16'h0096);
        sw_in = 8'h3E; #1;
        check("R8 before edge", {8'h00, rdata}, 16'h0096);
        @(posedge clk); #1;
        check("R8 after edge", {8'h00, rdata}, 16'h003E);
        idle();
    endtask

    task automatic t_reset_again();
        drive(12'h600, 1'b0, 1'b1, 8'hEE); @(posedge clk); #1;
        check("R5 pre", {8'h00, disp_q}, 16'h00EE);
        idle(); rst = 1'b1; @(posedge clk); #1; rst = 1'b0;
        check("R7 disp again", {8'h00, disp_q}, 16'h0000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1; rst = 1'b0;
        t_reset();
        t_select();
        t_display();
        t_read();
        t_switch();
        t_reset_again();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule